// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one SDRAM READ or WRITE burst request into the column addresses the burst visits, one per clock. A request is a one-cycle start strobe carrying a starting column, a three-bit length code and an ordering bit. From the next clock on, the block presents a column address with a valid flag. It raises a last flag on the final beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned group of columns whose size equals the burst length. The upper column bits name that group and the low bits step through it, either by incrementing with wrap-around or by XOR with the beat number. A full-page burst steps through every column of the page, wraps from the top column back to column 0, and runs until a terminate strobe stops it. A length code that is not defined, or a full-page request with interleaved ordering, is refused: the block raises an error flag for one cycle and issues no address.

Top module: `burst_colgen`

## Requirements
- R1: While reset is held, and in the first cycle after it, `valid_o`, `last_o` and `error_o` are low.
- R2: A start with a legal mode gives its first address on the next cycle, equal to `col_i`. After that one address follows per clock, with `valid_o` high on every beat.
- R3: Length codes are 3'b000=1, 3'b001=2, 3'b010=4, 3'b011=8 and 3'b111=full page. Full page is legal only with `interleave_i`=0. Full page with `interleave_i`=1 is reported through `error_o` as in R9.
- R4: For a fixed burst of 2^k beats, column bits [COL_W-1:k] of every beat equal those of the starting column.
- R5: With `interleave_i`=0, the low k bits of beat b equal (start low bits + b) mod 2^k. With `interleave_i`=1, they equal (start low bits) XOR b.
- R6: `last_o` is high only on beat 2^k-1 of a fixed burst. In the cycle after that beat, `valid_o` is low unless a new start was given.
- R7: A full-page burst gives (start + b) mod 2^COL_W on beat b, wraps past the top column, never raises `last_o`, and keeps running until it is terminated.
- R8: If `term_i` is high in a cycle that shows a beat of any burst, that beat is the final one. `valid_o` is low in the next cycle.
- R9: A start with length code 3'b100, 3'b101 or 3'b110, or with the illegal pairing of R3, raises `error_o` for exactly one cycle. That cycle shows no valid address, and any running burst is abandoned.
- R10: A start received during a running burst replaces that burst at once. A start wins over `term_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start-of-burst strobe |
| len_code_i | input | 3 | Burst length code (R3) |
| interleave_i | input | 1 | 0 = sequential order, 1 = interleaved order |
| col_i | input | COL_W | Starting column address |
| term_i | input | 1 | Burst terminate strobe |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | `col_o` holds a beat |
| last_o | output | 1 | Final beat of a fixed burst |
| error_o | output | 1 | Refused mode, one-cycle pulse |

## Verification
The bench builds the block with COL_W=6, so a page holds 64 columns. This makes every starting column reachable for every fixed length and both orderings, which gives a full sweep of R4 and R5. The smaller page also lets a full-page burst cross its wrap point twice within a short run. Terminate, restart and refused-mode cases are then driven on top of running bursts.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;

   localparam int unsigned LEN_CODE_W    = 3;
   localparam int unsigned MAX_FIXED_LOG = 3;

   typedef enum logic [LEN_CODE_W-1:0] {
      LEN_1    = 3'b000,
      LEN_2    = 3'b001,
      LEN_4    = 3'b010,
      LEN_8    = 3'b011,
      LEN_PAGE = 3'b111
   } len_code_e;

   // Fixed lengths occupy the codes with a clear top bit; their two low
   // bits are log2 of the beat count.
   function automatic logic code_is_fixed(input logic [LEN_CODE_W-1:0] c);
      return (c[LEN_CODE_W-1] == 1'b0);
   endfunction

   function automatic logic code_is_page(input logic [LEN_CODE_W-1:0] c);
      return (c == LEN_PAGE);
   endfunction

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
   import burst_colgen_pkg::*;
#(
   parameter int unsigned COL_W          = 9,
   parameter bit          HAS_INTERLEAVE = 1'b1
) (
   input  logic [LEN_CODE_W-1:0] code_i,
   input  logic                  interleave_i,
   output logic                  legal_o,
   output logic                  page_o,
   output logic [COL_W-1:0]      mask_o
);

   localparam int unsigned LOG_W = 2;

   logic [LOG_W-1:0] log_len;
   logic             fixed;
   logic             order_ok;

   assign fixed   = code_is_fixed(code_i);
   assign page_o  = code_is_page(code_i);
   assign log_len = code_i[LOG_W-1:0];

   // Interleaved order needs an aligned power-of-two block, so it pairs
   // only with fixed lengths, and only when the variant carries it.
   generate
      if (HAS_INTERLEAVE) begin : g_order_full
         assign order_ok = !(interleave_i && page_o);
      end else begin : g_order_seq_only
         assign order_ok = !interleave_i;
      end
   endgenerate

   assign legal_o = (fixed || page_o) && order_ok;

   // Bit gi is a wrapping bit when gi < log2(length); a page burst wraps
   // through every bit.
   for (genvar gi = 0; gi < COL_W; gi++) begin : g_mask
      if (gi < MAX_FIXED_LOG) begin : g_low
         assign mask_o[gi] = page_o | (32'(log_len) > 32'(gi));
      end else begin : g_high
         assign mask_o[gi] = page_o;
      end
   end

endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq #(
   parameter int unsigned COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             term_i,
   input  logic             legal_i,
   input  logic             page_i,
   input  logic             interleave_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic [COL_W-1:0] col_i,
   output logic             active_o,
   output logic             final_o,
   output logic             err_o,
   output logic             inter_o,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] beat_o,
   output logic [COL_W-1:0] mask_o
);

   logic             active_q;
   logic             err_q;
   logic             page_q;
   logic             inter_q;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] beat_q;
   logic [COL_W-1:0] mask_q;
   logic             final_beat;

   // A fixed burst ends when the beat count reaches length-1, which is the
   // mask value; a page burst has no natural end.
   assign final_beat = active_q && !page_q && (beat_q == mask_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         err_q    <= 1'b0;
         page_q   <= 1'b0;
         inter_q  <= 1'b0;
         base_q   <= '0;
         beat_q   <= '0;
         mask_q   <= '0;
      end else begin
         err_q <= 1'b0;
         if (start_i) begin
            if (legal_i) begin
               active_q <= 1'b1;
               beat_q   <= '0;
               base_q   <= col_i;
               mask_q   <= mask_i;
               page_q   <= page_i;
               inter_q  <= interleave_i;
            end else begin
               active_q <= 1'b0;
               err_q    <= 1'b1;
            end
         end else if (active_q) begin
            if (term_i || final_beat) begin
               active_q <= 1'b0;
            end else begin
               beat_q <= beat_q + 1'b1;
            end
         end
      end
   end

   assign active_o = active_q;
   assign final_o  = final_beat;
   assign err_o    = err_q;
   assign inter_o  = inter_q;
   assign base_o   = base_q;
   assign beat_o   = beat_q;
   assign mask_o   = mask_q;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
   parameter int unsigned COL_W          = 9,
   parameter bit          HAS_INTERLEAVE = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             inter_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] sum;

   // Full-width add; bits outside the mask are replaced by the base, so
   // carries out of the block never reach the output.
   assign sum = base_i + beat_i;

   for (genvar gi = 0; gi < COL_W; gi++) begin : g_bit
      if (HAS_INTERLEAVE) begin : g_two_orders
         assign col_o[gi] = !mask_i[gi] ? base_i[gi] :
                            inter_i     ? (base_i[gi] ^ beat_i[gi]) :
                                          sum[gi];
      end else begin : g_seq_only
         assign col_o[gi] = mask_i[gi] ? sum[gi] : base_i[gi];
      end
   end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
   import burst_colgen_pkg::*;
#(
   parameter int unsigned COL_W          = 9,
   parameter bit          HAS_INTERLEAVE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [LEN_CODE_W-1:0] len_code_i,
   input  logic                  interleave_i,
   input  logic [COL_W-1:0]      col_i,
   input  logic                  term_i,
   output logic [COL_W-1:0]      col_o,
   output logic                  valid_o,
   output logic                  last_o,
   output logic                  error_o
);

   generate
      if (COL_W < MAX_FIXED_LOG + 1) begin : g_bad_width
         $error("burst_colgen: COL_W must exceed the largest fixed block");
      end
      if (COL_W > 16) begin : g_too_wide
         $error("burst_colgen: COL_W above 16 is not supported");
      end
   endgenerate

   logic             dec_legal;
   logic             dec_page;
   logic [COL_W-1:0] dec_mask;
   logic             seq_active;
   logic             seq_final;
   logic             seq_err;
   logic             seq_inter;
   logic [COL_W-1:0] seq_base;
   logic [COL_W-1:0] seq_beat;
   logic [COL_W-1:0] seq_mask;

   burst_len_decode #(
      .COL_W          (COL_W),
      .HAS_INTERLEAVE (HAS_INTERLEAVE)
   ) u_decode (
      .code_i       (len_code_i),
      .interleave_i (interleave_i),
      .legal_o      (dec_legal),
      .page_o       (dec_page),
      .mask_o       (dec_mask)
   );

   burst_beat_seq #(
      .COL_W (COL_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .term_i       (term_i),
      .legal_i      (dec_legal),
      .page_i       (dec_page),
      .interleave_i (interleave_i),
      .mask_i       (dec_mask),
      .col_i        (col_i),
      .active_o     (seq_active),
      .final_o      (seq_final),
      .err_o        (seq_err),
      .inter_o      (seq_inter),
      .base_o       (seq_base),
      .beat_o       (seq_beat),
      .mask_o       (seq_mask)
   );

   burst_addr_gen #(
      .COL_W          (COL_W),
      .HAS_INTERLEAVE (HAS_INTERLEAVE)
   ) u_addr (
      .base_i  (seq_base),
      .beat_i  (seq_beat),
      .mask_i  (seq_mask),
      .inter_i (seq_inter),
      .col_o   (col_o)
   );

   assign valid_o = seq_active;
   assign last_o  = seq_final;
   assign error_o = seq_err;

endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
   parameter int unsigned COL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [2:0]       len_code_i,
   input logic             interleave_i,
   input logic [COL_W-1:0] col_i,
   input logic             term_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o,
   input logic             error_o
);

   logic [COL_W-1:0] blk_mask_q;
   logic [COL_W-1:0] req_mask;

   // The checker forms its own view of the block size for each request.
   always_comb begin
      if (len_code_i == 3'b111) req_mask = '1;
      else req_mask = COL_W'((32'd1 << len_code_i[1:0]) - 32'd1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) blk_mask_q <= '0;
      else if (start_i) blk_mask_q <= req_mask;
   end

   // R6
   a_r6_last_is_beat: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   // R6
   a_r6_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !valid_o);

   // R8
   a_r8_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (term_i && valid_o && !start_i) |=> !valid_o);

   // R9
   a_r9_error_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
      error_o |-> !valid_o);

   // R3
   a_r3_page_interleave_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && len_code_i == 3'b111 && interleave_i) |=> error_o);

   // R2
   a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !len_code_i[2]) |=> (valid_o && col_o == $past(col_i)));

   // R4
   a_r4_block_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(valid_o) && !$past(start_i))
         |-> ((col_o & ~blk_mask_q) == ($past(col_o) & ~blk_mask_q)));

endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_colgen_bench.sv
module burst_colgen_bench;

   localparam int CW = 6;
   localparam int PAGE = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [2:0]    len_code_i = 3'b000;
   logic          interleave_i = 1'b0;
   logic [CW-1:0] col_i = '0;
   logic          term_i = 1'b0;
   logic [CW-1:0] col_o;
   logic          valid_o;
   logic          last_o;
   logic          error_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   burst_colgen #(.COL_W(CW)) u_burst_colgen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_code_i(len_code_i),
      .interleave_i(interleave_i), .col_i(col_i), .term_i(term_i),
      .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .error_o(error_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Expected address from the requirements: block bits kept, low bits
   // stepped by add or XOR.
   function automatic int exp_col(input int col, input int code, input bit il, input int b);
      int mask;
      int low;
      mask = (code == 7) ? PAGE - 1 : (1 << code) - 1;
      low  = il ? ((col ^ b) & mask) : ((col + b) & mask);
      return (col & ~mask & (PAGE - 1)) | low;
   endfunction

   task automatic issue(input int code, input bit il, input int col);
      @(negedge clk);
      start_i = 1'b1; len_code_i = 3'(code); interleave_i = il; col_i = CW'(col);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // R2 R4 R5 R6: a complete fixed burst
   task automatic run_fixed(input int code, input bit il, input int col);
      int n;
      n = 1 << code;
      issue(code, il, col);
      for (int b = 0; b < n; b++) begin
         check("R2 valid", int'(valid_o), 1);
         check("R4/R5 col", int'(col_o), exp_col(col, code, il, b));
         check("R6 last", int'(last_o), (b == n - 1) ? 1 : 0);
         if (b < n - 1) @(negedge clk);
      end
      @(negedge clk);
      check("R6 idle after last", int'(valid_o), 0);
   endtask

   // R7 R8: page burst terminated after nb beats
   task automatic run_page(input int col, input int nb);
      issue(7, 1'b0, col);
      for (int b = 0; b < nb; b++) begin
         check("R7 valid", int'(valid_o), 1);
         check("R7 col", int'(col_o), (col + b) % PAGE);
         check("R7 no last", int'(last_o), 0);
         if (b == nb - 1) term_i = 1'b1;
         @(negedge clk);
      end
      term_i = 1'b0;
      check("R8 stop after term", int'(valid_o), 0);
   endtask

   initial begin
      // R1
      repeat (3) @(negedge clk);
      check("R1 valid in reset", int'(valid_o), 0);
      check("R1 error in reset", int'(error_o), 0);
      check("R1 last in reset", int'(last_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", int'(valid_o), 0);
      check("R1 error after reset", int'(error_o), 0);

      // R3 R4 R5: every start column, every fixed length, both orders
      for (int code = 0; code < 4; code++)
         for (int il = 0; il < 2; il++)
            for (int c = 0; c < PAGE; c++)
               run_fixed(code, il[0], c);

      // R7: page bursts crossing the wrap point
      run_page(0, 2 * PAGE + 3);
      run_page(PAGE - 2, 5);
      run_page(37, 1);

      // R8: terminate a fixed burst of 8 on its third beat
      issue(3, 1'b0, 13);
      for (int b = 0; b < 3; b++) begin
         check("R8 col before term", int'(col_o), exp_col(13, 3, 1'b0, b));
         if (b == 2) term_i = 1'b1;
         @(negedge clk);
      end
      term_i = 1'b0;
      check("R8 fixed burst stopped", int'(valid_o), 0);
      check("R8 no last", int'(last_o), 0);

      // R9: reserved codes abandon a running burst
      for (int code = 4; code < 7; code++) begin
         issue(3, 1'b0, 8);
         @(negedge clk);
         start_i = 1'b1; len_code_i = 3'(code); interleave_i = 1'b0;
         @(negedge clk);
         start_i = 1'b0;
         check("R9 error pulse", int'(error_o), 1);
         check("R9 no valid", int'(valid_o), 0);
         @(negedge clk);
         check("R9 error one cycle", int'(error_o), 0);
         check("R9 burst abandoned", int'(valid_o), 0);
      end

      // R3: page with interleave is refused
      issue(7, 1'b1, 4);
      check("R3 page+interleave error", int'(error_o), 1);
      check("R3 page+interleave no valid", int'(valid_o), 0);
      @(negedge clk);
      check("R3 error clears", int'(error_o), 0);

      // R10: restart during a burst, start beating term
      issue(3, 1'b0, 0);
      @(negedge clk);
      start_i = 1'b1; term_i = 1'b1; len_code_i = 3'd2; interleave_i = 1'b1; col_i = CW'(22);
      @(negedge clk);
      start_i = 1'b0; term_i = 1'b0;
      for (int b = 0; b < 4; b++) begin
         check("R10 restart valid", int'(valid_o), 1);
         check("R10 restart col", int'(col_o), exp_col(22, 2, 1'b1, b));
         check("R10 restart last", int'(last_o), (b == 3) ? 1 : 0);
         @(negedge clk);
      end
      check("R10 idle", int'(valid_o), 0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

endmodule